// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central bookkeeping unit of a dynamically scheduled pipeline. It has five functional units: one integer/load unit, two multipliers, one adder and one divider. Decoded instructions arrive in program order on an issue port. Each one passes through four steps: issue, operand read, execution, and result write. The block decides when each step may happen. It keeps a status record per unit and a table that maps every architectural register to the unit that will produce it. Execution is modelled as a per-unit latency counter. No data values, operand buses or arithmetic exist here, only grants and tables.

Hazards are handled without forwarding:
- A write-after-write conflict or a busy unit stops issue.
- A read-after-write conflict delays the operand read.
- A write-after-read conflict holds back the result write.

Issue is strictly in order. The sender must hold a refused instruction, and everything behind it waits.

Each unit has a four-state machine:
- `U_IDLE`: free.
- `U_OPWAIT`: issued and waiting for its operands.
- `U_EXEC`: counting its latency.
- `U_DONE`: finished and waiting for write permission.

Its transitions are:
- issue: `U_IDLE` to `U_OPWAIT`.
- operand read: `U_OPWAIT` to `U_EXEC`.
- completion: `U_EXEC` to `U_DONE`.
- write grant: `U_DONE` to `U_IDLE`.

Top module: `sb_ctrl`

## Requirements
- R1: After reset all units are idle: `rd_grant`, `cmp_pulse` and `wb_grant` are zero. An integer instruction to a free register shows `iss_ready` = 1 with `iss_unit` = 0.
- R2: `iss_ready` is 0 while every unit of the requested class is occupied, from its issue through its write-grant cycle.
- R3: `iss_ready` is 0 while the requested destination is pending from any issued instruction. This includes the cycle in which that producer receives its write grant.
- R4: Unit indices are integer 0, multipliers 1 and 2, adder 3 and divider 4. Class codes are 0 integer, 1 multiply, 2 add and 3 divide. A multiply goes to the lowest-numbered free multiplier.
- R5: An instruction whose source is pending receives its operand-read grant exactly one cycle after that producer's write grant, and never before.
- R6: With no hazard, `rd_grant` rises in the cycle after acceptance. `cmp_pulse` rises LAT cycles after `rd_grant`, where LAT is 1 for integer, 4 for multiply, 2 for add and 8 for divide. `wb_grant` rises in the following cycle.
- R7: A finished unit's write grant is withheld while another unit that has not yet read its operands names the finished unit's destination as a ready source. The grant comes the cycle after that reader's `rd_grant`.
- R8: At most one `wb_grant` bit is set per cycle, and the lowest-numbered finished unit wins.
- R9: During a write grant, `wb_dst` shows the unit's destination. From the next cycle the unit and that register are free for issue.
- R10: If an instruction is accepted in the same cycle as the write grant of the producer of its source, that source counts as ready. Its operand read is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction present on the issue port |
| iss_class | input | 2 | Unit class of the instruction |
| iss_dst | input | $clog2(REGS) | Destination register |
| iss_src1 | input | $clog2(REGS) | First source register |
| iss_src2 | input | $clog2(REGS) | Second source register |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_unit | output | 3 | Unit that would receive the instruction |
| rd_grant | output | 5 | Per-unit operand-read grant |
| cmp_pulse | output | 5 | Per-unit execution-complete pulse |
| wb_grant | output | 5 | Per-unit result-write grant (one-hot or zero) |
| wb_dst | output | $clog2(REGS) | Register written under the current grant |

## Verification
The hardest case to reach is the write-after-read hold. The held unit must have finished while an older instruction is still unread and names its destination. That older instruction must itself be stalled by a slower producer. The stimulus builds this case from three instructions:
- a long divide, whose destination feeds a multiply;
- that multiply, which also reads a register;
- a short add, which overwrites that register.

The add finishes first and must wait until the multiply reads, which only happens after the divide's write. The same-cycle case of issue against write grant is reached by presenting the consumer in the cycle when the integer producer's grant is visible.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int NFU  = 5;
    localparam int TAGW = 3;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } fu_class_t;

    typedef enum logic [1:0] {
        U_IDLE   = 2'd0,
        U_OPWAIT = 2'd1,
        U_EXEC   = 2'd2,
        U_DONE   = 2'd3
    } ustate_t;
endpackage

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sb_unit.sv
module sb_unit
    import sbc_pkg::*;
#(
    parameter int RW  = 5,
    parameter int LAT = 1,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [RW-1:0]   in_fi,
    input  logic [RW-1:0]   in_fj,
    input  logic [RW-1:0]   in_fk,
    input  logic [TAGW-1:0] in_qj,
    input  logic [TAGW-1:0] in_qk,
    input  logic            in_rj,
    input  logic            in_rk,
    input  logic            wb_fire,
    input  logic [TAGW-1:0] wb_tag,
    input  logic            wb_win,
    input  logic            war_hold,
    output ustate_t         st,
    output logic [RW-1:0]   fi,
    output logic [RW-1:0]   fj,
    output logic [RW-1:0]   fk,
    output logic            rj,
    output logic            rk,
    output logic            rd_gnt,
    output logic            cmp,
    output logic            wb_req
);
    ustate_t         st_nx;
    logic [TAGW-1:0] qj, qk;
    logic [CW-1:0]   cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            U_IDLE:   if (take)           st_nx = U_OPWAIT;
            U_OPWAIT: if (rj && rk)       st_nx = U_EXEC;
            U_EXEC:   if (cnt == CW'(1))  st_nx = U_DONE;
            U_DONE:   if (wb_win)         st_nx = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= U_IDLE;
            cnt <= '0;
            fi  <= '0;
            fj  <= '0;
            fk  <= '0;
            qj  <= '0;
            qk  <= '0;
            rj  <= 1'b0;
            rk  <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == U_IDLE && take) begin
                fi <= in_fi;
                fj <= in_fj;
                fk <= in_fk;
                qj <= in_rj ? '0 : in_qj;
                qk <= in_rk ? '0 : in_qk;
                rj <= in_rj;
                rk <= in_rk;
            end else if (st == U_OPWAIT) begin
                if (rj && rk) begin
                    rj  <= 1'b0;
                    rk  <= 1'b0;
                    cnt <= CW'(LAT);
                end else begin
                    if (wb_fire && !rj && qj == wb_tag) begin
                        rj <= 1'b1;
                        qj <= '0;
                    end
                    if (wb_fire && !rk && qk == wb_tag) begin
                        rk <= 1'b1;
                        qk <= '0;
                    end
                end
            end else if (st == U_EXEC) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    always_comb begin
        rd_gnt = (st == U_OPWAIT) && rj && rk;
        cmp    = (st == U_EXEC) && (cnt == CW'(1));
        wb_req = (st == U_DONE) && !war_hold;
    end

    p_read_to_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> (st == U_EXEC));
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> (!rj && !rk));
    p_done_after_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp |=> (st == U_DONE));
    p_war_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_DONE && war_hold) |=> (st == U_DONE));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_win |=> (st == U_IDLE));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sbc_pkg::*;
#(
    parameter int REGS    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 4,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 8,
    localparam int RW     = $clog2(REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [1:0]      iss_class,
    input  logic [RW-1:0]   iss_dst,
    input  logic [RW-1:0]   iss_src1,
    input  logic [RW-1:0]   iss_src2,
    output logic            iss_ready,
    output logic [2:0]      iss_unit,
    output logic [NFU-1:0]  rd_grant,
    output logic [NFU-1:0]  cmp_pulse,
    output logic [NFU-1:0]  wb_grant,
    output logic [RW-1:0]   wb_dst
);
    logic [TAGW-1:0] prod [REGS];
    ustate_t         ust  [NFU];
    logic [RW-1:0]   fi_a [NFU];
    logic [RW-1:0]   fj_a [NFU];
    logic [RW-1:0]   fk_a [NFU];
    logic [NFU-1:0]  rj_v, rk_v, busy, take, hold, req;
    logic            sel_ok, accept, wb_any, rj_in, rk_in;
    logic [TAGW-1:0] sel, wb_idx, wb_tag, qj_in, qk_in;

    always_comb begin
        for (int u = 0; u < NFU; u++) busy[u] = (ust[u] != U_IDLE);
    end

    always_comb begin
        sel_ok = 1'b0;
        sel    = '0;
        unique case (fu_class_t'(iss_class))
            CL_INT: if (!busy[0]) begin sel_ok = 1'b1; sel = 3'd0; end
            CL_MUL: begin
                if (!busy[1])      begin sel_ok = 1'b1; sel = 3'd1; end
                else if (!busy[2]) begin sel_ok = 1'b1; sel = 3'd2; end
            end
            CL_ADD: if (!busy[3]) begin sel_ok = 1'b1; sel = 3'd3; end
            CL_DIV: if (!busy[4]) begin sel_ok = 1'b1; sel = 3'd4; end
        endcase
    end

    assign iss_ready = sel_ok && (prod[iss_dst] == '0);
    assign iss_unit  = sel;
    assign accept    = iss_valid && iss_ready;
    assign wb_tag    = wb_idx + TAGW'(1);
    assign qj_in     = prod[iss_src1];
    assign qk_in     = prod[iss_src2];
    assign rj_in     = (qj_in == '0) || (wb_any && qj_in == wb_tag);
    assign rk_in     = (qk_in == '0) || (wb_any && qk_in == wb_tag);

    always_comb begin
        for (int u = 0; u < NFU; u++) take[u] = accept && (sel == TAGW'(u));
    end

    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            hold[u] = 1'b0;
            for (int f = 0; f < NFU; f++) begin
                if (f != u && ust[f] == U_OPWAIT &&
                    ((fj_a[f] == fi_a[u] && rj_v[f]) ||
                     (fk_a[f] == fi_a[u] && rk_v[f])))
                    hold[u] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NFU; g++) begin : g_unit
        localparam int L = (g == 0) ? LAT_INT :
                           (g <= 2) ? LAT_MUL :
                           (g == 3) ? LAT_ADD : LAT_DIV;
        sb_unit #(.RW(RW), .LAT(L)) u_fu (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take[g]),
            .in_fi    (iss_dst),
            .in_fj    (iss_src1),
            .in_fk    (iss_src2),
            .in_qj    (qj_in),
            .in_qk    (qk_in),
            .in_rj    (rj_in),
            .in_rk    (rk_in),
            .wb_fire  (wb_any),
            .wb_tag   (wb_tag),
            .wb_win   (wb_grant[g]),
            .war_hold (hold[g]),
            .st       (ust[g]),
            .fi       (fi_a[g]),
            .fj       (fj_a[g]),
            .fk       (fk_a[g]),
            .rj       (rj_v[g]),
            .rk       (rk_v[g]),
            .rd_gnt   (rd_grant[g]),
            .cmp      (cmp_pulse[g]),
            .wb_req   (req[g])
        );
    end

    sb_wb_arb #(.N(NFU), .IW(TAGW)) u_arb (
        .req (req),
        .gnt (wb_grant),
        .any (wb_any),
        .idx (wb_idx)
    );

    always_comb begin
        wb_dst = '0;
        for (int u = 0; u < NFU; u++) if (wb_grant[u]) wb_dst = fi_a[u];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) prod[r] <= '0;
        end else begin
            if (wb_any) prod[wb_dst] <= '0;
            if (accept) prod[iss_dst] <= sel + TAGW'(1);
        end
    end

    p_one_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));
    p_grant_only_requesters_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_grant & ~req) == '0);
    p_accept_marks_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (prod[$past(iss_dst)] != '0));
endmodule

// File: tb/tb_sb_ctrl.sv
module tb_sb_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       iss_valid;
    logic [1:0] iss_class;
    logic [4:0] iss_dst, iss_src1, iss_src2;
    logic       iss_ready;
    logic [2:0] iss_unit;
    logic [4:0] rd_grant, cmp_pulse, wb_grant, wb_dst;
    int vecs = 0;
    int errs = 0;

    always #10 clk = ~clk;

    sb_ctrl dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .iss_unit(iss_unit), .rd_grant(rd_grant),
        .cmp_pulse(cmp_pulse), .wb_grant(wb_grant), .wb_dst(wb_dst)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    task automatic do_reset;
        iss_valid = 1'b0; iss_class = 2'd0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic present(input int c, input int d, input int s1, input int s2);
        iss_class = 2'(c); iss_dst = 5'(d); iss_src1 = 5'(s1); iss_src2 = 5'(s2);
        #1;
    endtask

    task automatic issue(input int c, input int d, input int s1, input int s2);
        present(c, d, s1, s2);
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1", "rd_grant", int'(rd_grant), 0);
        chk("R1", "cmp_pulse", int'(cmp_pulse), 0);
        chk("R1", "wb_grant", int'(wb_grant), 0);
        present(0, 1, 2, 3);
        chk("R1", "iss_ready", int'(iss_ready), 1);
        chk("R1", "iss_unit", int'(iss_unit), 0);
    endtask

    task automatic t_plain;
        do_reset();
        issue(0, 1, 2, 3);
        chk("R6", "int rd_grant", int'(rd_grant), 5'b00001);
        @(negedge clk);
        chk("R6", "int cmp_pulse", int'(cmp_pulse), 5'b00001);
        @(negedge clk);
        chk("R6", "int wb_grant", int'(wb_grant), 5'b00001);
        chk("R9", "wb_dst", int'(wb_dst), 1);
        @(negedge clk);
        chk("R9", "wb_grant clear", int'(wb_grant), 0);
        do_reset();
        issue(3, 6, 7, 8);
        chk("R6", "div rd_grant", int'(rd_grant), 5'b10000);
        for (int i = 0; i < 7; i++) @(negedge clk);
        chk("R6", "div cmp early", int'(cmp_pulse), 0);
        @(negedge clk);
        chk("R6", "div cmp", int'(cmp_pulse), 5'b10000);
    endtask

    task automatic t_struct;
        bit seen = 0;
        do_reset();
        present(1, 1, 5, 5);
        chk("R4", "first mul unit", int'(iss_unit), 1);
        issue(1, 1, 5, 5);
        present(1, 2, 5, 5);
        chk("R4", "second mul unit", int'(iss_unit), 2);
        issue(1, 2, 5, 5);
        present(1, 3, 5, 5);
        chk("R2", "mul stall", int'(iss_ready), 0);
        present(2, 4, 5, 5);
        chk("R4", "add ready", int'(iss_ready), 1);
        chk("R4", "add unit", int'(iss_unit), 3);
        present(1, 3, 5, 5);
        for (int i = 0; i < 20 && !seen; i++) begin
            if (wb_grant[1]) begin
                seen = 1;
                chk("R2", "mul stall in wb cycle", int'(iss_ready), 0);
            end else @(negedge clk);
        end
        chk("R9", "mul1 wb seen", int'(seen), 1);
        @(negedge clk);
        present(1, 3, 5, 5);
        chk("R9", "mul ready after wb", int'(iss_ready), 1);
        chk("R9", "mul unit reused", int'(iss_unit), 1);
    endtask

    task automatic t_waw;
        bit seen = 0;
        do_reset();
        issue(3, 5, 1, 2);
        for (int i = 0; i < 20 && !seen; i++) begin
            present(2, 5, 3, 4);
            if (iss_ready !== 1'b0) chk("R3", "waw stall", int'(iss_ready), 0);
            if (wb_grant[4]) begin
                seen = 1;
                chk("R3", "waw stall at wb", int'(iss_ready), 0);
                chk("R9", "div wb_dst", int'(wb_dst), 5);
            end else @(negedge clk);
        end
        @(negedge clk);
        present(2, 5, 3, 4);
        chk("R9", "waw lifted", int'(iss_ready), 1);
    endtask

    task automatic t_raw;
        bit seen = 0;
        do_reset();
        issue(1, 6, 2, 3);
        issue(2, 7, 6, 1);
        for (int i = 0; i < 20 && !seen; i++) begin
            if (rd_grant[3]) chk("R5", "early read", 1, 0);
            if (wb_grant[1]) seen = 1;
            else @(negedge clk);
        end
        chk("R5", "producer wb seen", int'(seen), 1);
        chk("R5", "no read in wb cycle", int'(rd_grant[3]), 0);
        @(negedge clk);
        chk("R5", "read after wb", int'(rd_grant[3]), 1);
    endtask

    task automatic t_war;
        bit cseen = 0;
        bit rseen = 0;
        do_reset();
        issue(3, 8, 1, 1);
        issue(1, 9, 8, 2);
        issue(2, 2, 3, 4);
        for (int i = 0; i < 20 && !cseen; i++) begin
            if (cmp_pulse[3]) cseen = 1;
            else @(negedge clk);
        end
        chk("R7", "add complete seen", int'(cseen), 1);
        @(negedge clk);
        chk("R7", "add held", int'(wb_grant[3]), 0);
        for (int i = 0; i < 20 && !rseen; i++) begin
            if (wb_grant[3]) chk("R7", "wb before read", 1, 0);
            if (rd_grant[1]) rseen = 1;
            else @(negedge clk);
        end
        chk("R7", "mul read seen", int'(rseen), 1);
        @(negedge clk);
        chk("R7", "add wb after read", int'(wb_grant), 5'b01000);
        chk("R7", "add wb_dst", int'(wb_dst), 2);
    endtask

    task automatic t_prio;
        do_reset();
        issue(2, 11, 1, 1);
        issue(0, 12, 1, 1);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "int wins", int'(wb_grant), 5'b00001);
        chk("R8", "int dst", int'(wb_dst), 12);
        @(negedge clk);
        chk("R8", "add next", int'(wb_grant), 5'b01000);
        chk("R8", "add dst", int'(wb_dst), 11);
    endtask

    task automatic t_same_cycle;
        do_reset();
        issue(0, 13, 1, 1);
        @(negedge clk);
        @(negedge clk);
        chk("R10", "producer wb", int'(wb_grant), 5'b00001);
        present(2, 14, 13, 13);
        chk("R10", "consumer ready", int'(iss_ready), 1);
        issue(2, 14, 13, 13);
        chk("R10", "consumer read", int'(rd_grant), 5'b01000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_struct();
        t_waw();
        t_raw();
        t_war();
        t_prio();
        t_same_cycle();
        summary();
        $finish;
    end
endmodule